// File: doc/BRIEF.md
# Unipolar Stepper Phase Sequencer

This block converts a step-and-direction command stream into the four gate-drive signals of a unipolar two-phase stepper motor: A, A-bar, B and B-bar. A fast system clock samples the asynchronous command inputs. A qualified rising edge on the step input moves a 3-bit phase position, counted in half steps, forward or back. The position is decoded into the phase outputs. The current chopper and the power stage sit after this block.

Two excitation schemes are available. Full step keeps two phases on at all times. Half step alternates between one and two phases, giving eight states per electrical cycle. The scheme can change while the motor turns without losing rotor position. A drive-enable input blanks the outputs while the position keeps tracking the step edges, so drive resumes in step with the command stream. A step edge counts only once the step input has stayed high for `MIN_HIGH` system clocks, which rejects glitches and short pulses.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst_n` is low, all four phase outputs are 0, whatever the other inputs do.
- R2: After `rst_n` is released with drive enabled, the outputs show A and B-bar on, i.e. `{ph_a,ph_an,ph_b,ph_bn}` = 4'b1001 (position 0).
- R3: In half-step mode (`half_mode`=1) with `dir_rev`=0, each accepted step advances the position by one through this output order `{ph_a,ph_an,ph_b,ph_bn}`: 1001, 1000, 1010, 0010, 0110, 0100, 0101, 0001, then back to 1001.
- R4: With `dir_rev`=1, each accepted step walks the R3 order backwards by one state (half step) or by two states (full step).
- R5: In full-step mode (`half_mode`=0), starting from a two-phase state, each accepted step moves two positions in the R3 order, so only two-phase states (1001, 1010, 0110, 0101) appear.
- R6: A change of `half_mode` alone does not change the outputs. The mode is sampled at the accepted step. A full-mode step taken from a one-phase state moves one position in the step direction, onto the adjacent two-phase state.
- R7: While `drive_en` is low, all outputs are 0 and accepted steps still move the position. When `drive_en` returns high, the outputs show the state for the accumulated steps.
- R8: With no step pulses, the outputs hold their present state indefinitely.
- R9: A step is accepted only when `step_in` stays high for at least `MIN_HIGH` consecutive system clocks. A shorter pulse, and any falling edge, leaves the position unchanged. A long high pulse counts as exactly one step.
- R10: A and A-bar are never on together, and B and B-bar are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all command inputs |
| rst_n | input | 1 | Active-low reset; forces outputs off and position to 0 |
| step_in | input | 1 | Step command; a qualified rising edge moves one step |
| half_mode | input | 1 | 0 = full step two-phase on, 1 = half step |
| dir_rev | input | 1 | 0 = forward, 1 = reverse |
| drive_en | input | 1 | 0 blanks all outputs; position still tracks steps |
| ph_a | output | 1 | Gate drive, phase A |
| ph_an | output | 1 | Gate drive, phase A-bar |
| ph_b | output | 1 | Gate drive, phase B |
| ph_bn | output | 1 | Gate drive, phase B-bar |

## Verification
Some properties are checked on every cycle. The winding pairs stay mutually exclusive, the outputs stay off during reset and during a sustained disable, and the position stays frozen while the step input has been low. The step orderings need the bench's scenarios: forward, reverse, full step and half step. So do the alignment step after a mode change, the recovery of accumulated position on re-enable, and the rejection of a pulse one clock short of the qualifier. A reference model in the bench predicts each of these states, and a scoreboard compares them with the outputs.

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
  parameter int MIN_HIGH = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,
  input  logic half_mode,
  input  logic dir_rev,
  input  logic drive_en,
  output logic ph_a,
  output logic ph_an,
  output logic ph_b,
  output logic ph_bn
);
  localparam int CW = $clog2(MIN_HIGH + 1);

  logic [3:0]    sy1, sy2;
  logic [CW-1:0] hi_cnt;
  logic [2:0]    pos;
  logic [3:0]    dec;

  wire step_s = sy2[3];
  wire half_s = sy2[2];
  wire rev_s  = sy2[1];
  wire en_s   = sy2[0];

  wire       fire = step_s && (hi_cnt == CW'(MIN_HIGH - 1));
  wire [2:0] unit = rev_s ? 3'b111 : 3'b001;
  wire [2:0] inc  = (half_s || pos[0]) ? unit : {unit[1:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1    <= '0;
      sy2    <= '0;
      hi_cnt <= '0;
      pos    <= '0;
    end else begin
      sy1 <= {step_in, half_mode, dir_rev, drive_en};
      sy2 <= sy1;
      if (!step_s)
        hi_cnt <= '0;
      else if (hi_cnt != CW'(MIN_HIGH))
        hi_cnt <= hi_cnt + 1'b1;
      if (fire)
        pos <= pos + inc;
    end
  end

  always_comb begin
    case (pos)
      3'd0: dec = 4'b1001;
      3'd1: dec = 4'b1000;
      3'd2: dec = 4'b1010;
      3'd3: dec = 4'b0010;
      3'd4: dec = 4'b0110;
      3'd5: dec = 4'b0100;
      3'd6: dec = 4'b0101;
      default: dec = 4'b0001;
    endcase
  end

  assign {ph_a, ph_an, ph_b, ph_bn} = en_s ? dec : 4'b0000;
endmodule

module stepper_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step_in,
  input logic       drive_en,
  input logic [2:0] pos,
  input logic       ph_a,
  input logic       ph_an,
  input logic       ph_b,
  input logic       ph_bn
);
  always @(posedge clk)
    if (!rst_n)
      a_r1_off_in_reset: assert ({ph_a, ph_an, ph_b, ph_bn} == 4'b0000);

  a_r10_a_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_a && ph_an));

  a_r10_b_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_b && ph_bn));

  a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_en && !$past(drive_en) && !$past(drive_en, 2))
      |-> ({ph_a, ph_an, ph_b, ph_bn} == 4'b0000));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(step_in, 2) && !$past(step_in, 3) && !$past(step_in, 4))
      |-> $stable(pos));
endmodule

bind stepper_phase_seq stepper_phase_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step_in(step_in), .drive_en(drive_en),
  .pos(pos), .ph_a(ph_a), .ph_an(ph_an), .ph_b(ph_b), .ph_bn(ph_bn)
);

// File: tb/tb_stepper_phase_seq.sv
`timescale 1ns/1ps
module tb_stepper_phase_seq;
  localparam int MINH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, step_in = 1'b0, half_mode = 1'b1, dir_rev = 1'b0, drive_en = 1'b1;
  logic ph_a, ph_an, ph_b, ph_bn;

  stepper_phase_seq #(.MIN_HIGH(MINH)) dut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .half_mode(half_mode),
    .dir_rev(dir_rev), .drive_en(drive_en),
    .ph_a(ph_a), .ph_an(ph_an), .ph_b(ph_b), .ph_bn(ph_bn)
  );

  typedef struct { logic [3:0] v; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  int mpos = 0;
  bit mhalf = 1'b1;
  bit done = 1'b0;

  function automatic logic [3:0] ref_state(int p);
    case (p)
      0: return 4'b1001; 1: return 4'b1000; 2: return 4'b1010; 3: return 4'b0010;
      4: return 4'b0110; 5: return 4'b0100; 6: return 4'b0101; default: return 4'b0001;
    endcase
  endfunction

  task automatic expect_out(logic [3:0] v, string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(int w);
    @(negedge clk) step_in = 1'b1;
    repeat (w) @(negedge clk);
    step_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_step(string tag);
    int d;
    pulse(MINH);
    d = dir_rev ? -1 : 1;
    if (mhalf || (mpos % 2 == 1)) mpos = (mpos + d + 8) % 8;
    else mpos = (mpos + 2 * d + 8) % 8;
    expect_out(drive_en ? ref_state(mpos) : 4'b0000, tag);
  endtask

  task automatic set_mode(bit h);
    @(negedge clk) half_mode = h;
    mhalf = h;
    repeat (4) @(negedge clk);
  endtask

  always @(negedge clk) begin
    exp_t e;
    logic [3:0] got;
    if (q.size() > 0) begin
      e = q.pop_front();
      got = {ph_a, ph_an, ph_b, ph_bn};
      checks++;
      if (got !== e.v) begin
        errors++;
        $display("FAIL %s: got %b expected %b", e.tag, got, e.v);
      end
      checks++;
      if ((ph_a && ph_an) || (ph_b && ph_bn)) begin
        errors++;
        $display("FAIL R10 exclusive pairs: got %b expected no pair on", got);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    expect_out(4'b0000, "R1 outputs off in reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_out(4'b1001, "R2 first state after reset");

    for (int i = 0; i < 8; i++) do_step("R3 forward half step");

    @(negedge clk) dir_rev = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) do_step("R4 reverse half step");

    @(negedge clk) dir_rev = 1'b0;
    repeat (4) @(negedge clk);
    set_mode(1'b0);
    expect_out(ref_state(mpos), "R6 mode change alone keeps state");
    do_step("R6 full step aligns from one-phase state");
    do_step("R5 full step forward");
    do_step("R5 full step forward");
    @(negedge clk) dir_rev = 1'b1;
    repeat (4) @(negedge clk);
    do_step("R4 reverse full step");
    do_step("R4 reverse full step");
    @(negedge clk) dir_rev = 1'b0;
    repeat (4) @(negedge clk);

    set_mode(1'b1);
    expect_out(ref_state(mpos), "R6 switch to half keeps state");
    do_step("R6 half step after mode switch");

    @(negedge clk) drive_en = 1'b0;
    repeat (4) @(negedge clk);
    expect_out(4'b0000, "R7 outputs blanked");
    for (int i = 0; i < 3; i++) do_step("R7 step while blanked");
    @(negedge clk) drive_en = 1'b1;
    repeat (4) @(negedge clk);
    expect_out(ref_state(mpos), "R7 resume at accumulated position");

    repeat (60) @(negedge clk);
    expect_out(ref_state(mpos), "R8 hold with no steps");

    pulse(MINH - 1);
    expect_out(ref_state(mpos), "R9 short pulse rejected");
    pulse(MINH * 5);
    mpos = (mpos + 1) % 8;
    expect_out(ref_state(mpos), "R9 long pulse counts once");

    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    expect_out(4'b0000, "R1 outputs off in mid-run reset");
    mpos = 0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    expect_out(4'b1001, "R2 initial state after mid-run reset");

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule